// File: doc/BRIEF.md
# Partitionable Signed/Unsigned Multiplier Array

This block is one bank of multiplier hardware that can be split at run time into lanes of three sizes: eight narrow lanes of 9 x 9 bits, four middle lanes of 18 x 18 bits, or a single wide lane of 36 x 36 bits. The lane size is set by a mode input. Two sign inputs, one for each operand, select two's-complement or unsigned interpretation. Both sign inputs apply to every lane at once, and each product is kept at full precision.

Operands, sign inputs and the mode are captured together in an input register stage, so the controls stay in step with the data. The operand A register can also act as a shift register: each lane takes the A value held by the lane below it, which lets one operand stream feed all lanes. An optional product register adds one pipeline stage. The wide lane is built from four 18 x 18 partial products taken from the middle-lane multipliers. Only the upper half of a signed wide operand is sign-extended.

Top module: `split_mult_array`

## Requirements
- R1: An asynchronous active-low reset clears the input, control and product registers. While reset is low, `prod_o` is all zeros.
- R2: Mode `2'b00` gives eight narrow lanes. Lane i multiplies `a_i[9i+8:9i]` by `b_i[9i+8:9i]`, and the 18-bit product goes to `prod_o[18i+17:18i]`.
- R3: Mode `2'b01` gives four middle lanes. Lane j multiplies `a_i[18j+17:18j]` by `b_i[18j+17:18j]`, and the 36-bit product goes to `prod_o[36j+35:36j]`.
- R4: Mode `2'b10` or `2'b11` gives one wide lane. It multiplies `a_i[35:0]` by `b_i[35:0]` into `prod_o[71:0]`. Operand bits 71:36 have no effect, and `prod_o[143:72]` is zero.
- R5: `sign_a_i`/`sign_b_i` = 1 treats operand A/B as two's complement, and 0 treats it as unsigned. The product is signed when either operand is signed. Its width is the sum of the operand widths and it is exact for every operand value, including the most-negative and all-ones values.
- R6: Mode and both sign inputs are registered on the same edge as the operands, so each result uses the controls given with its own operands, even when the controls change on every cycle.
- R7: Operands sampled on one rising edge appear on `prod_o` after the following rising edge (OUT_REG = 1). Before that edge, `prod_o` keeps the previous result.
- R8: With `shift_i` = 1, the A register is shifted up by one lane width of the mode given in that cycle (9, 18 or 36 bits). Lane 0 loads the low lane-width bits of `a_i`, the other `a_i` bits have no effect, and B loads in parallel as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Lane size: 00 narrow, 01 middle, 1x wide |
| sign_a_i | input | 1 | Operand A is two's complement when 1 |
| sign_b_i | input | 1 | Operand B is two's complement when 1 |
| shift_i | input | 1 | Load A as a shift chain instead of in parallel |
| a_i | input | 72 | Packed A operands |
| b_i | input | 72 | Packed B operands |
| prod_o | output | 144 | Packed full-precision products |

## Verification
With the default product register, a result appears two rising edges after its operands are driven. The bench drives on the falling edge and samples on the falling edge that follows the second rising edge. In the back-to-back scenario, the bench samples one edge earlier to confirm that the old product is still present, then reads the two new results on the next two falling edges, each with its own mode and sign setting. The shift scenarios add one rising edge for each shift cycle, and each expected value is computed from the operand the shift chain should hold at that point.

// File: rtl/sma_pkg.sv
package sma_pkg;

   localparam logic [1:0] MODE_NARROW = 2'b00;
   localparam logic [1:0] MODE_MID    = 2'b01;

   function automatic logic mode_is_wide(input logic [1:0] m);
      return m[1];
   endfunction

   function automatic logic mode_is_mid(input logic [1:0] m);
      return (m == MODE_MID);
   endfunction

endpackage

// File: rtl/sma_in_stage.sv
module sma_in_stage
   import sma_pkg::*;
#(
   parameter int LW    = 9,
   parameter int LANES = 8
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [1:0]          mode_i,
   input  logic                sign_a_i,
   input  logic                sign_b_i,
   input  logic                shift_i,
   input  logic [LANES*LW-1:0] a_i,
   input  logic [LANES*LW-1:0] b_i,
   output logic [1:0]          mode_o,
   output logic                sa_o,
   output logic                sb_o,
   output logic [LANES*LW-1:0] a_o,
   output logic [LANES*LW-1:0] b_o
);

   localparam int W  = LANES * LW;
   localparam int MW = 2 * LW;
   localparam int QW = 4 * LW;

   logic [W-1:0] a_d;

   // Shift distance follows the lane size requested in the same cycle
   always_comb begin
      if (!shift_i)
         a_d = a_i;
      else if (mode_is_wide(mode_i))
         a_d = {a_o[W-QW-1:0], a_i[QW-1:0]};
      else if (mode_is_mid(mode_i))
         a_d = {a_o[W-MW-1:0], a_i[MW-1:0]};
      else
         a_d = {a_o[W-LW-1:0], a_i[LW-1:0]};
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mode_o <= '0;
         sa_o   <= 1'b0;
         sb_o   <= 1'b0;
         a_o    <= '0;
         b_o    <= '0;
      end else begin
         mode_o <= mode_i;
         sa_o   <= sign_a_i;
         sb_o   <= sign_b_i;
         a_o    <= a_d;
         b_o    <= b_i;
      end
   end

   // R8: narrow shift moves every lane up by one position
   a_r8_narrow_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) && $past(shift_i) && ($past(mode_i) == MODE_NARROW)
      |-> a_o[W-1:LW] == $past(a_o[W-LW-1:0]));

   // R8: operand B always loads in parallel
   a_r8_b_parallel: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> b_o == $past(b_i));

   // R6: sign controls travel with the operands
   a_r6_sign_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> (sa_o == $past(sign_a_i)) && (sb_o == $past(sign_b_i)));

endmodule

// File: rtl/sma_lanes.sv
module sma_lanes
   import sma_pkg::*;
#(
   parameter int LW    = 9,
   parameter int LANES = 8
) (
   input  logic [1:0]            mode_i,
   input  logic                  sa_i,
   input  logic                  sb_i,
   input  logic [LANES*LW-1:0]   a_i,
   input  logic [LANES*LW-1:0]   b_i,
   output logic [2*LANES*LW-1:0] p_o
);

   localparam int W      = LANES * LW;
   localparam int MW     = 2 * LW;
   localparam int MLANES = LANES / 2;
   localparam int QW     = 4 * LW;

   logic [2*W-1:0]  p_nar;
   logic [2*W-1:0]  p_mid;
   logic [2*QW-1:0] p_wide;
   logic            wide;

   assign wide = mode_is_wide(mode_i);

   // Narrow lanes: operands extended to product width, low bits are exact
   for (genvar i = 0; i < LANES; i++) begin : g_nar
      logic [2*LW-1:0] xa, xb;
      assign xa = {{LW{sa_i & a_i[i*LW+LW-1]}}, a_i[i*LW +: LW]};
      assign xb = {{LW{sb_i & b_i[i*LW+LW-1]}}, b_i[i*LW +: LW]};
      assign p_nar[i*2*LW +: 2*LW] = xa * xb;
   end

   // Middle lanes; the first four also serve as wide-lane partial products
   for (genvar j = 0; j < MLANES; j++) begin : g_mid
      logic [MW-1:0]   opa, opb;
      logic            ea, eb;
      logic [2*MW-1:0] xa, xb;

      if (j < 4) begin : g_shared
         localparam bit HI_A = (j % 2) == 1;
         localparam bit HI_B = j >= 2;
         always_comb begin
            if (wide) begin
               opa = HI_A ? a_i[MW +: MW] : a_i[0 +: MW];
               opb = HI_B ? b_i[MW +: MW] : b_i[0 +: MW];
               // lower halves of a wide operand are always unsigned
               ea  = HI_A & sa_i & a_i[2*MW-1];
               eb  = HI_B & sb_i & b_i[2*MW-1];
            end else begin
               opa = a_i[j*MW +: MW];
               opb = b_i[j*MW +: MW];
               ea  = sa_i & a_i[j*MW+MW-1];
               eb  = sb_i & b_i[j*MW+MW-1];
            end
         end
      end else begin : g_plain
         assign opa = a_i[j*MW +: MW];
         assign opb = b_i[j*MW +: MW];
         assign ea  = sa_i & a_i[j*MW+MW-1];
         assign eb  = sb_i & b_i[j*MW+MW-1];
      end

      assign xa = {{MW{ea}}, opa};
      assign xb = {{MW{eb}}, opb};
      assign p_mid[j*2*MW +: 2*MW] = xa * xb;
   end

   // Wide lane: recombine lo*lo, hi*lo, lo*hi, hi*hi
   logic [2*MW-1:0] pp_ll, pp_hl, pp_lh, pp_hh;
   logic            ext_hl, ext_lh;

   assign pp_ll  = p_mid[0*2*MW +: 2*MW];
   assign pp_hl  = p_mid[1*2*MW +: 2*MW];
   assign pp_lh  = p_mid[2*2*MW +: 2*MW];
   assign pp_hh  = p_mid[3*2*MW +: 2*MW];
   // cross terms are signed only when their upper-half operand is signed
   assign ext_hl = sa_i & pp_hl[2*MW-1];
   assign ext_lh = sb_i & pp_lh[2*MW-1];

   assign p_wide = {pp_hh, {(2*MW){1'b0}}}
                 + {{MW{ext_hl}}, pp_hl, {MW{1'b0}}}
                 + {{MW{ext_lh}}, pp_lh, {MW{1'b0}}}
                 + {{(2*MW){1'b0}}, pp_ll};

   always_comb begin
      if (wide)
         p_o = {{(2*W-2*QW){1'b0}}, p_wide};
      else if (mode_is_mid(mode_i))
         p_o = p_mid;
      else
         p_o = p_nar;
   end

endmodule

// File: rtl/sma_out_stage.sv
module sma_out_stage #(
   parameter int W       = 144,
   parameter int OUT_REG = 1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (OUT_REG != 0) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) q_o <= '0;
         else         q_o <= d_i;
      end
   end else begin : g_pass
      assign q_o = d_i;
   end

endmodule

// File: rtl/split_mult_array.sv
module split_mult_array
   import sma_pkg::*;
#(
   parameter int LW      = 9,
   parameter int LANES   = 8,
   parameter int OUT_REG = 1
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic [1:0]            mode_i,
   input  logic                  sign_a_i,
   input  logic                  sign_b_i,
   input  logic                  shift_i,
   input  logic [LANES*LW-1:0]   a_i,
   input  logic [LANES*LW-1:0]   b_i,
   output logic [2*LANES*LW-1:0] prod_o
);

   localparam int W  = LANES * LW;
   localparam int QW = 4 * LW;

   if (LANES < 8 || (LANES % 4) != 0) begin : g_bad_lanes
      $error("LANES must be a multiple of 4 and at least 8");
   end
   if (LW < 2) begin : g_bad_width
      $error("LW must be at least 2");
   end
   if (OUT_REG != 0 && OUT_REG != 1) begin : g_bad_outreg
      $error("OUT_REG must be 0 or 1");
   end

   logic [1:0]     mode_q;
   logic           sa_q, sb_q;
   logic [W-1:0]   a_q, b_q;
   logic [2*W-1:0] core_p;

   sma_in_stage #(.LW(LW), .LANES(LANES)) u_in (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .mode_i   (mode_i),
      .sign_a_i (sign_a_i),
      .sign_b_i (sign_b_i),
      .shift_i  (shift_i),
      .a_i      (a_i),
      .b_i      (b_i),
      .mode_o   (mode_q),
      .sa_o     (sa_q),
      .sb_o     (sb_q),
      .a_o      (a_q),
      .b_o      (b_q)
   );

   sma_lanes #(.LW(LW), .LANES(LANES)) u_lanes (
      .mode_i (mode_q),
      .sa_i   (sa_q),
      .sb_i   (sb_q),
      .a_i    (a_q),
      .b_i    (b_q),
      .p_o    (core_p)
   );

   sma_out_stage #(.W(2*W), .OUT_REG(OUT_REG)) u_out (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (core_p),
      .q_o    (prod_o)
   );

   // R4: wide mode leaves the upper product field empty
   a_r4_wide_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_is_wide(mode_q) |-> core_p[2*W-1:2*QW] == '0);

   // R5: unsigned wide product equals a direct full-width multiply
   a_r5_wide_unsigned: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_is_wide(mode_q) && !sa_q && !sb_q
      |-> core_p[2*QW-1:0] == ({{QW{1'b0}}, a_q[QW-1:0]} * {{QW{1'b0}}, b_q[QW-1:0]}));

   if (OUT_REG != 0) begin : g_lat_chk
      // R7: product register adds exactly one edge
      a_r7_one_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $past(rst_ni) |-> prod_o == $past(core_p));
   end

endmodule

// File: tb/tb_split_mult_array.sv
`timescale 1ns/1ps
module tb_split_mult_array;

   logic         clk = 1'b0;
   logic         rst_ni;
   logic [1:0]   mode;
   logic         sa, sb, shift;
   logic [71:0]  a, b;
   logic [143:0] prod_o;
   logic [143:0] last_exp;
   int           checks = 0;
   int           errors = 0;

   always #5 clk = ~clk;

   split_mult_array dut (
      .clk_i    (clk),
      .rst_ni   (rst_ni),
      .mode_i   (mode),
      .sign_a_i (sa),
      .sign_b_i (sb),
      .shift_i  (shift),
      .a_i      (a),
      .b_i      (b),
      .prod_o   (prod_o)
   );

   function automatic logic [71:0] ref_mul(input logic [35:0] x, input logic [35:0] y,
                                           input int w, input logic sx, input logic sy);
      logic signed [75:0] xa, xb, pr, msk;
      xa = $signed({40'b0, x});
      xb = $signed({40'b0, y});
      if (sx && x[w-1]) xa = xa - (76'sd1 <<< w);
      if (sy && y[w-1]) xb = xb - (76'sd1 <<< w);
      pr  = xa * xb;
      msk = (76'sd1 <<< (2*w)) - 76'sd1;
      pr  = pr & msk;
      return pr[71:0];
   endfunction

   function automatic logic [143:0] expect_p(input logic [1:0] m, input logic s1, input logic s2,
                                             input logic [71:0] x, input logic [71:0] y);
      logic [143:0] e;
      logic [71:0]  t;
      e = '0;
      if (m == 2'b00) begin
         for (int i = 0; i < 8; i++) begin
            t = ref_mul({27'b0, x[i*9 +: 9]}, {27'b0, y[i*9 +: 9]}, 9, s1, s2);
            e[i*18 +: 18] = t[17:0];
         end
      end else if (m == 2'b01) begin
         for (int i = 0; i < 4; i++) begin
            t = ref_mul({18'b0, x[i*18 +: 18]}, {18'b0, y[i*18 +: 18]}, 18, s1, s2);
            e[i*36 +: 36] = t[35:0];
         end
      end else begin
         t = ref_mul(x[35:0], y[35:0], 36, s1, s2);
         e[71:0] = t;
      end
      return e;
   endfunction

   task automatic chk(input string tag, input logic [143:0] act, input logic [143:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [1:0] m, input logic s1, input logic s2,
                        input logic [71:0] x, input logic [71:0] y, input logic sh);
      mode = m; sa = s1; sb = s2; a = x; b = y; shift = sh;
   endtask

   task automatic run_op(input string tag, input logic [1:0] m, input logic s1, input logic s2,
                         input logic [71:0] x, input logic [71:0] y);
      logic [143:0] e;
      e = expect_p(m, s1, s2, x, y);
      @(negedge clk); drive(m, s1, s2, x, y, 1'b0);
      @(negedge clk);
      @(negedge clk);
      chk(tag, prod_o, e);
      last_exp = e;
   endtask

   // R1: reset clears everything, even with busy inputs
   task automatic t_reset();
      rst_ni = 1'b0;
      drive(2'b00, 1'b1, 1'b1, {8{9'h1FF}}, {8{9'h155}}, 1'b0);
      repeat (3) @(negedge clk);
      chk("R1 reset holds output at zero", prod_o, '0);
      rst_ni = 1'b1;
      last_exp = expect_p(2'b00, 1'b1, 1'b1, {8{9'h1FF}}, {8{9'h155}});
   endtask

   task automatic t_reset_async();
      run_op("R1 pre-reset op", 2'b01, 1'b1, 1'b0, {4{18'h2ABCD}}, {4{18'h1F00F}});
      #2 rst_ni = 1'b0;
      #1 chk("R1 async clear", prod_o, '0);
      @(negedge clk); rst_ni = 1'b1;
      last_exp = expect_p(2'b01, 1'b1, 1'b0, {4{18'h2ABCD}}, {4{18'h1F00F}});
   endtask

   // R2 R5: narrow lanes, all sign combinations, corner values
   task automatic t_narrow();
      logic [71:0] pa [3];
      logic [71:0] pb [3];
      pa[0] = {8{9'h100}}; pb[0] = {8{9'h100}};
      pa[1] = {8{9'h1FF}}; pb[1] = {8{9'h1FF}};
      pa[2] = {9'h100, 9'h1FF, 9'h0FF, 9'h001, 9'h000, 9'h0AA, 9'h155, 9'h17F};
      pb[2] = {9'h1FF, 9'h100, 9'h100, 9'h0FF, 9'h1FF, 9'h003, 9'h12C, 9'h080};
      for (int p = 0; p < 3; p++)
         for (int s = 0; s < 4; s++)
            run_op("R2 R5 narrow lanes", 2'b00, s[1], s[0], pa[p], pb[p]);
   endtask

   // R3 R5: middle lanes
   task automatic t_mid();
      logic [71:0] pa [3];
      logic [71:0] pb [3];
      pa[0] = {4{18'h20000}}; pb[0] = {4{18'h20000}};
      pa[1] = {4{18'h3FFFF}}; pb[1] = {4{18'h3FFFF}};
      pa[2] = {18'h20000, 18'h3FFFF, 18'h1FFFF, 18'h00001};
      pb[2] = {18'h3FFFF, 18'h20000, 18'h12345, 18'h2F0F0};
      for (int p = 0; p < 3; p++)
         for (int s = 0; s < 4; s++)
            run_op("R3 R5 middle lanes", 2'b01, s[1], s[0], pa[p], pb[p]);
   endtask

   // R4 R5: wide lane, upper operand bits filled with junk
   task automatic t_wide();
      logic [71:0] pa [3];
      logic [71:0] pb [3];
      pa[0] = {36'hFFFFFFFFF, 36'h800000000}; pb[0] = {36'h123456789, 36'h800000000};
      pa[1] = {36'h5A5A5A5A5, 36'hFFFFFFFFF}; pb[1] = {36'h000000000, 36'hFFFFFFFFF};
      pa[2] = {36'h000000000, 36'h7FFFFFFFF}; pb[2] = {36'hFFF000FFF, 36'h800000001};
      for (int p = 0; p < 3; p++)
         for (int s = 0; s < 4; s++)
            run_op("R4 R5 wide lane", 2'b10, s[1], s[0], pa[p], pb[p]);
      run_op("R4 mode 11 acts as wide", 2'b11, 1'b1, 1'b1, pa[0], pb[0]);
   endtask

   // R6 R7: controls change every cycle, latency observed
   task automatic t_pipeline();
      logic [71:0]  xa, xb, ya, yb;
      logic [143:0] ex, ey;
      xa = {9'h100, 9'h1FF, 9'h0FF, 9'h001, 9'h000, 9'h0AA, 9'h155, 9'h17F};
      xb = {8{9'h1FF}};
      ya = {36'hABCDEF012, 36'h800000000};
      yb = {36'h111111111, 36'hFFFFFFFFF};
      ex = expect_p(2'b00, 1'b1, 1'b0, xa, xb);
      ey = expect_p(2'b10, 1'b0, 1'b1, ya, yb);
      @(negedge clk); drive(2'b00, 1'b1, 1'b0, xa, xb, 1'b0);
      @(negedge clk);
      chk("R7 old product kept one edge", prod_o, last_exp);
      drive(2'b10, 1'b0, 1'b1, ya, yb, 1'b0);
      @(negedge clk);
      chk("R6 first result uses own controls", prod_o, ex);
      @(negedge clk);
      chk("R6 second result uses own controls", prod_o, ey);
      last_exp = ey;
   endtask

   // R8: shift chain behaviour
   task automatic t_shift();
      logic [71:0] p, q1, q2, bb;
      p  = 72'h9A_1234_5678_9ABC_DEF0;
      q1 = 72'hFF_FFFF_FFFF_FFFF_FE0B;
      q2 = 72'h55_5555_5555_5555_5143;
      bb = {9'h003, 9'h1FF, 9'h100, 9'h011, 9'h0F0, 9'h123, 9'h07F, 9'h1AB};
      // single narrow shift
      @(negedge clk); drive(2'b00, 1'b1, 1'b1, p, bb, 1'b0);
      @(negedge clk); drive(2'b00, 1'b1, 1'b1, q1, bb, 1'b1);
      @(negedge clk); drive(2'b00, 1'b1, 1'b1, q1, bb, 1'b0);
      @(negedge clk);
      chk("R8 narrow single shift", prod_o,
          expect_p(2'b00, 1'b1, 1'b1, {p[62:0], q1[8:0]}, bb));
      // two narrow shifts back to back
      @(negedge clk); drive(2'b00, 1'b0, 1'b1, p, bb, 1'b0);
      @(negedge clk); drive(2'b00, 1'b0, 1'b1, q1, bb, 1'b1);
      @(negedge clk); drive(2'b00, 1'b0, 1'b1, q2, bb, 1'b1);
      @(negedge clk); drive(2'b00, 1'b0, 1'b1, q2, bb, 1'b0);
      @(negedge clk);
      chk("R8 narrow double shift", prod_o,
          expect_p(2'b00, 1'b0, 1'b1, {p[53:0], q1[8:0], q2[8:0]}, bb));
      // middle-width shift
      @(negedge clk); drive(2'b01, 1'b1, 1'b0, p, bb, 1'b0);
      @(negedge clk); drive(2'b01, 1'b1, 1'b0, q2, bb, 1'b1);
      @(negedge clk); drive(2'b01, 1'b1, 1'b0, q2, bb, 1'b0);
      @(negedge clk);
      chk("R8 middle shift", prod_o,
          expect_p(2'b01, 1'b1, 1'b0, {p[53:0], q2[17:0]}, bb));
      last_exp = expect_p(2'b01, 1'b1, 1'b0, q2, bb);
   endtask

   initial begin
      drive(2'b00, 1'b0, 1'b0, '0, '0, 1'b0);
      last_exp = '0;
      t_reset();
      t_narrow();
      t_mid();
      t_wide();
      t_pipeline();
      t_shift();
      t_reset_async();
      run_op("R2 narrow after reset", 2'b00, 1'b1, 1'b1, {8{9'h1FF}}, {8{9'h100}});
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule